// File: doc/BRIEF.md
# Programmable Logic Output Macrocell Bank

This block is a bank of identical output cells that sit behind a programmable AND array. Each cell ORs its own group of product terms and can invert the result. It then sends to its port pin either that combinational value or the value held in a D flip-flop. Each flip-flop runs from either the shared pin clock or a per-cell product-term clock. It has an asynchronous product-term preset and an asynchronous clear. The clear comes from the gated device reset, from a per-cell product term, or from both.

Each cell also returns a feedback bit to the array: the stored value for state machines, or the combinational value for expanding another cell's term count. This works even when the pin is showing something else. A product term drives the pin's output enable. A pin set up as an input places its pad value on the array's input bus. All configuration arrives as static vectors, and the clock selection must not change while the block runs.

Top module: `pld_mc_bank`

## Requirements
- R1: In combinational mode (`cfg_reg_out[i]`=0), `pin_out[i]` equals the OR of the cell's terms `pt_terms[i*PT_W +: PT_W]`, XORed with `cfg_invert[i]`, with no clock involved.
- R2: With `cfg_reg_out[i]`=1 and `cfg_pt_clock[i]`=0, each rising edge of `pin_clk` stores the cell's combinational value, and `pin_out[i]` shows the stored bit.
- R3: With `cfg_pt_clock[i]`=1, the cell stores only on rising edges of `pt_clk[i]`, and `pin_clk` edges leave it unchanged.
- R4: Asserting `pt_clr[i]` clears the stored bit at once when `cfg_clr_pt[i]`=1, and has no effect when `cfg_clr_pt[i]`=0.
- R5: Asserting `pt_pre[i]` sets the stored bit to 1 at once, and the bit then holds across `pin_clk` edges in product-term clock mode.
- R6: When the clear and the preset of a cell are both active, the stored bit is 0.
- R7: `fb_out[i]` is the stored bit when `cfg_fb_reg[i]`=1 and the combinational value otherwise, whatever `pin_out[i]` shows.
- R8: `pin_oe[i]` = `pt_oe[i]` AND NOT `cfg_pin_in[i]`. `in_bus[i]` carries `pin_in[i]` when `cfg_pin_in[i]`=1 and is 0 otherwise.
- R9: `dev_rst` clears the stored bit only when both `rst_en`=1 and `cfg_clr_rst[i]`=1. Otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pin_clk | input | 1 | Shared clock pin |
| dev_rst | input | 1 | Device reset, active high, asynchronous |
| rst_en | input | 1 | Lets the device reset reach the cells |
| pt_terms | input | N_CELLS*PT_W | Product terms, cell i at bits i*PT_W upward |
| pt_clk | input | N_CELLS | Per-cell product-term clock |
| pt_clr | input | N_CELLS | Per-cell product-term clear |
| pt_pre | input | N_CELLS | Per-cell product-term preset |
| pt_oe | input | N_CELLS | Per-cell output-enable term |
| cfg_invert | input | N_CELLS | Invert the OR result |
| cfg_reg_out | input | N_CELLS | 1: pin shows stored bit, 0: combinational |
| cfg_pt_clock | input | N_CELLS | 1: product-term clock, 0: pin clock (static) |
| cfg_clr_rst | input | N_CELLS | Accept gated device reset as clear |
| cfg_clr_pt | input | N_CELLS | Accept product-term clear |
| cfg_fb_reg | input | N_CELLS | 1: feedback from stored bit, 0: combinational |
| cfg_pin_in | input | N_CELLS | Pin used as input |
| pin_in | input | N_CELLS | Pad input values |
| pin_out | output | N_CELLS | Pin output values |
| pin_oe | output | N_CELLS | Pin output enables |
| fb_out | output | N_CELLS | Feedback to the array |
| in_bus | output | N_CELLS | Pin inputs placed on the array bus |

## Verification
A wrong stored bit shows on `pin_out` in registered mode, or on `fb_out` when feedback comes from the register. It appears as soon as the bad capture or async event occurs, which is one `pin_clk` edge at most. A cell that takes the wrong clock shows as a pin-clock capture in a cell that should hold, or a missed capture after a `pt_clk` pulse, in the same half period. A wrong clear or preset path appears combinationally, while the product term is still held.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
   typedef struct packed {
      logic invert;
      logic reg_out;
      logic pt_clock;
      logic clr_from_rst;
      logic clr_from_pt;
      logic fb_from_reg;
      logic pin_is_input;
   } mc_cfg_t;
endpackage

// File: rtl/mc_sum.sv
module mc_sum #(
   parameter int PT_W = 10
) (
   input  logic [PT_W-1:0] terms,
   input  logic            invert,
   output logic            sum
);
   always_comb sum = (|terms) ^ invert;
endmodule

// File: rtl/mc_flop.sv
module mc_flop (
   input  logic clk,
   input  logic clr,
   input  logic pre,
   input  logic d,
   output logic q
);
   always_ff @(posedge clk or posedge clr or posedge pre) begin
      if (clr)      q <= 1'b0;
      else if (pre) q <= 1'b1;
      else          q <= d;
   end
endmodule

// File: rtl/mc_cell.sv
module mc_cell
   import pld_mc_pkg::*;
#(
   parameter int PT_W = 10
) (
   input  logic            pin_clk,
   input  logic            shared_clr,
   input  mc_cfg_t         cfg,
   input  logic [PT_W-1:0] terms,
   input  logic            t_clk,
   input  logic            t_clr,
   input  logic            t_pre,
   input  logic            t_oe,
   input  logic            pad_in,
   output logic            pad_out,
   output logic            pad_oe,
   output logic            fb,
   output logic            bus_in
);
   logic comb_v;
   logic store_q;
   logic ff_clk;
   logic ff_clr;

   mc_sum #(.PT_W(PT_W)) u_sum (
      .terms (terms),
      .invert(cfg.invert),
      .sum   (comb_v)
   );

   assign ff_clk = cfg.pt_clock ? t_clk : pin_clk;
   assign ff_clr = (cfg.clr_from_rst & shared_clr) | (cfg.clr_from_pt & t_clr);

   mc_flop u_flop (
      .clk(ff_clk),
      .clr(ff_clr),
      .pre(t_pre),
      .d  (comb_v),
      .q  (store_q)
   );

   assign pad_out = cfg.reg_out ? store_q : comb_v;
   assign fb      = cfg.fb_from_reg ? store_q : comb_v;
   assign pad_oe  = t_oe & ~cfg.pin_is_input;
   assign bus_in  = pad_in & cfg.pin_is_input;
endmodule

// File: rtl/pld_mc_bank.sv
module pld_mc_bank
   import pld_mc_pkg::*;
#(
   parameter int N_CELLS = 8,
   parameter int PT_W    = 10
) (
   input  logic                    pin_clk,
   input  logic                    dev_rst,
   input  logic                    rst_en,
   input  logic [N_CELLS*PT_W-1:0] pt_terms,
   input  logic [N_CELLS-1:0]      pt_clk,
   input  logic [N_CELLS-1:0]      pt_clr,
   input  logic [N_CELLS-1:0]      pt_pre,
   input  logic [N_CELLS-1:0]      pt_oe,
   input  logic [N_CELLS-1:0]      cfg_invert,
   input  logic [N_CELLS-1:0]      cfg_reg_out,
   input  logic [N_CELLS-1:0]      cfg_pt_clock,
   input  logic [N_CELLS-1:0]      cfg_clr_rst,
   input  logic [N_CELLS-1:0]      cfg_clr_pt,
   input  logic [N_CELLS-1:0]      cfg_fb_reg,
   input  logic [N_CELLS-1:0]      cfg_pin_in,
   input  logic [N_CELLS-1:0]      pin_in,
   output logic [N_CELLS-1:0]      pin_out,
   output logic [N_CELLS-1:0]      pin_oe,
   output logic [N_CELLS-1:0]      fb_out,
   output logic [N_CELLS-1:0]      in_bus
);
   localparam int TERMS_TOTAL = N_CELLS * PT_W;

   if (N_CELLS < 1) begin : g_bad_cells
      $error("pld_mc_bank: N_CELLS must be at least 1");
   end
   if (PT_W < 1) begin : g_bad_terms
      $error("pld_mc_bank: PT_W must be at least 1");
   end
   if (TERMS_TOTAL > 4096) begin : g_bad_total
      $error("pld_mc_bank: product-term bus too wide");
   end

   logic shared_clr;
   assign shared_clr = dev_rst & rst_en;

   for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      mc_cfg_t cell_cfg;
      assign cell_cfg = '{
         invert:       cfg_invert[i],
         reg_out:      cfg_reg_out[i],
         pt_clock:     cfg_pt_clock[i],
         clr_from_rst: cfg_clr_rst[i],
         clr_from_pt:  cfg_clr_pt[i],
         fb_from_reg:  cfg_fb_reg[i],
         pin_is_input: cfg_pin_in[i]
      };

      mc_cell #(.PT_W(PT_W)) u_cell (
         .pin_clk   (pin_clk),
         .shared_clr(shared_clr),
         .cfg       (cell_cfg),
         .terms     (pt_terms[i*PT_W +: PT_W]),
         .t_clk     (pt_clk[i]),
         .t_clr     (pt_clr[i]),
         .t_pre     (pt_pre[i]),
         .t_oe      (pt_oe[i]),
         .pad_in    (pin_in[i]),
         .pad_out   (pin_out[i]),
         .pad_oe    (pin_oe[i]),
         .fb        (fb_out[i]),
         .bus_in    (in_bus[i])
      );
   end
endmodule

// File: rtl/pld_mc_bank_chk.sv
module pld_mc_bank_chk #(
   parameter int N_CELLS = 8,
   parameter int PT_W    = 10
) (
   input logic                    pin_clk,
   input logic                    dev_rst,
   input logic                    rst_en,
   input logic [N_CELLS*PT_W-1:0] pt_terms,
   input logic [N_CELLS-1:0]      pt_clr,
   input logic [N_CELLS-1:0]      pt_pre,
   input logic [N_CELLS-1:0]      pt_oe,
   input logic [N_CELLS-1:0]      cfg_invert,
   input logic [N_CELLS-1:0]      cfg_reg_out,
   input logic [N_CELLS-1:0]      cfg_pt_clock,
   input logic [N_CELLS-1:0]      cfg_clr_rst,
   input logic [N_CELLS-1:0]      cfg_clr_pt,
   input logic [N_CELLS-1:0]      cfg_fb_reg,
   input logic [N_CELLS-1:0]      cfg_pin_in,
   input logic [N_CELLS-1:0]      pin_in,
   input logic [N_CELLS-1:0]      pin_out,
   input logic [N_CELLS-1:0]      pin_oe,
   input logic [N_CELLS-1:0]      fb_out,
   input logic [N_CELLS-1:0]      in_bus
);
   logic [N_CELLS-1:0] exp_comb;
   logic [N_CELLS-1:0] clr_any;

   always_comb begin
      for (int i = 0; i < N_CELLS; i++) begin
         exp_comb[i] = (|pt_terms[i*PT_W +: PT_W]) ^ cfg_invert[i];
         clr_any[i]  = (cfg_clr_pt[i] & pt_clr[i]) | (cfg_clr_rst[i] & rst_en & dev_rst);
      end
   end

   for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
      // R1
      a_r1_comb_out: assert property (@(negedge pin_clk) disable iff (dev_rst)
         !cfg_reg_out[i] |-> pin_out[i] == exp_comb[i]);

      // R2
      a_r2_sync_capture: assert property (@(posedge pin_clk) disable iff (dev_rst)
         (cfg_reg_out[i] && !cfg_pt_clock[i] && !pt_pre[i] && !clr_any[i])
         |=> (pt_pre[i] || clr_any[i] || !cfg_reg_out[i] || cfg_pt_clock[i]
              || pin_out[i] == $past(exp_comb[i])));

      // R5
      a_r5_preset_sets: assert property (@(negedge pin_clk) disable iff (dev_rst)
         (pt_pre[i] && !clr_any[i] && cfg_fb_reg[i]) |-> fb_out[i]);

      // R6
      a_r6_clear_wins: assert property (@(negedge pin_clk) disable iff (dev_rst)
         (pt_pre[i] && clr_any[i] && cfg_fb_reg[i]) |-> !fb_out[i]);

      // R7
      a_r7_fb_comb: assert property (@(negedge pin_clk) disable iff (dev_rst)
         !cfg_fb_reg[i] |-> fb_out[i] == exp_comb[i]);
      a_r7_fb_reg_match: assert property (@(negedge pin_clk) disable iff (dev_rst)
         (cfg_fb_reg[i] && cfg_reg_out[i]) |-> fb_out[i] == pin_out[i]);

      // R8
      a_r8_oe_gated: assert property (@(negedge pin_clk) disable iff (dev_rst)
         pin_oe[i] |-> (pt_oe[i] && !cfg_pin_in[i]));
      a_r8_bus_gated: assert property (@(negedge pin_clk) disable iff (dev_rst)
         !cfg_pin_in[i] |-> !in_bus[i]);
      a_r8_bus_pass: assert property (@(negedge pin_clk) disable iff (dev_rst)
         cfg_pin_in[i] |-> in_bus[i] == pin_in[i]);
   end
endmodule

bind pld_mc_bank pld_mc_bank_chk #(.N_CELLS(N_CELLS), .PT_W(PT_W)) u_chk (
   .pin_clk     (pin_clk),
   .dev_rst     (dev_rst),
   .rst_en      (rst_en),
   .pt_terms    (pt_terms),
   .pt_clr      (pt_clr),
   .pt_pre      (pt_pre),
   .pt_oe       (pt_oe),
   .cfg_invert  (cfg_invert),
   .cfg_reg_out (cfg_reg_out),
   .cfg_pt_clock(cfg_pt_clock),
   .cfg_clr_rst (cfg_clr_rst),
   .cfg_clr_pt  (cfg_clr_pt),
   .cfg_fb_reg  (cfg_fb_reg),
   .cfg_pin_in  (cfg_pin_in),
   .pin_in      (pin_in),
   .pin_out     (pin_out),
   .pin_oe      (pin_oe),
   .fb_out      (fb_out),
   .in_bus      (in_bus)
);

// File: tb/tb_pld_mc_bank.sv
module tb_pld_mc_bank;
   localparam int CLK_P = 10;
   localparam int N     = 8;
   localparam int PW    = 10;

   logic          pin_clk = 1'b0;
   logic          dev_rst;
   logic          rst_en;
   logic [N*PW-1:0] pt_terms;
   logic [N-1:0]  pt_clk, pt_clr, pt_pre, pt_oe;
   logic [N-1:0]  cfg_invert, cfg_reg_out, cfg_pt_clock, cfg_clr_rst;
   logic [N-1:0]  cfg_clr_pt, cfg_fb_reg, cfg_pin_in, pin_in;
   logic [N-1:0]  pin_out, pin_oe, fb_out, in_bus;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [31:0] seed = 32'h1d2c3b4a;

   always #(CLK_P/2) pin_clk = ~pin_clk;

   pld_mc_bank #(.N_CELLS(N), .PT_W(PW)) dut (
      .pin_clk(pin_clk), .dev_rst(dev_rst), .rst_en(rst_en), .pt_terms(pt_terms),
      .pt_clk(pt_clk), .pt_clr(pt_clr), .pt_pre(pt_pre), .pt_oe(pt_oe),
      .cfg_invert(cfg_invert), .cfg_reg_out(cfg_reg_out), .cfg_pt_clock(cfg_pt_clock),
      .cfg_clr_rst(cfg_clr_rst), .cfg_clr_pt(cfg_clr_pt), .cfg_fb_reg(cfg_fb_reg),
      .cfg_pin_in(cfg_pin_in), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .fb_out(fb_out), .in_bus(in_bus)
   );

   function automatic logic [31:0] step(input logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   function automatic logic [N-1:0] comb_of(input logic [N*PW-1:0] t, input logic [N-1:0] inv);
      logic [N-1:0] e;
      for (int i = 0; i < N; i++) e[i] = (|t[i*PW +: PW]) ^ inv[i];
      return e;
   endfunction

   task automatic draw(output logic [31:0] v);
      seed = step(seed);
      v = seed;
   endtask

   task automatic rand_terms();
      logic [95:0] a, b, c;
      logic [31:0] w;
      for (int k = 0; k < 3; k++) begin
         draw(w); a[k*32 +: 32] = w;
         draw(w); b[k*32 +: 32] = w;
         draw(w); c[k*32 +: 32] = w;
      end
      pt_terms = a[N*PW-1:0] & b[N*PW-1:0] & c[N*PW-1:0];
   endtask

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp,
                      input logic [N-1:0] mask);
      checks++;
      if ((act & mask) !== (exp & mask)) begin
         fails++;
         $display("FAIL %s: actual %b expected %b (mask %b)", req, act & mask, exp & mask, mask);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // upper cells (product-term clocked) load a value through pt_clk
   task automatic load_upper(input logic v);
      @(negedge pin_clk);
      pt_terms   = '0;
      cfg_invert = v ? 8'hF0 : 8'h00;
      #1 pt_clk = 8'hF0;
      #1 pt_clk = 8'h00;
      #1;
   endtask

   initial begin
      #(CLK_P*100000);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] w;
      logic [N-1:0] e;
      logic [N-1:0] oe_set[3];
      logic [N-1:0] mode_set[3];
      dev_rst = 1; rst_en = 1; pt_terms = '0;
      pt_clk = '0; pt_clr = '0; pt_pre = '0; pt_oe = '0;
      cfg_invert = '0; cfg_reg_out = '1; cfg_pt_clock = 8'hF0;
      cfg_clr_rst = '1; cfg_clr_pt = '0; cfg_fb_reg = '1; cfg_pin_in = '0; pin_in = '0;
      repeat (3) @(negedge pin_clk);
      #1;
      chk("R9 reset state pin_out", pin_out, 8'h00, 8'hFF);
      chk("R9 reset state fb_out", fb_out, 8'h00, 8'hFF);
      @(negedge pin_clk);
      dev_rst = 0;

      // R1: combinational sweep, one term per cell rotated, several polarities
      cfg_reg_out = '0; cfg_fb_reg = '0;
      for (int p = 0; p < 3; p++) begin
         for (int b = 0; b <= PW; b++) begin
            @(negedge pin_clk);
            cfg_invert = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'h5A;
            pt_terms = '0;
            if (b < PW)
               for (int i = 0; i < N; i++) pt_terms[i*PW + ((b + i) % PW)] = 1'b1;
            #1;
            e = comb_of(pt_terms, cfg_invert);
            chk("R1 comb pin_out", pin_out, e, 8'hFF);
            chk("R7 comb feedback", fb_out, e, 8'hFF);
         end
      end
      for (int n = 0; n < 20; n++) begin
         @(negedge pin_clk);
         rand_terms(); draw(w); cfg_invert = w[7:0];
         #1;
         chk("R1 comb random", pin_out, comb_of(pt_terms, cfg_invert), 8'hFF);
      end

      // R2 / R3: registered mode, upper cells hold 1 across pin clock edges
      cfg_reg_out = '1;
      load_upper(1'b1);
      chk("R3 pt_clk capture of 1", pin_out, 8'hF0, 8'hF0);
      for (int n = 0; n < 30; n++) begin
         @(negedge pin_clk);
         rand_terms(); draw(w); cfg_invert = w[7:0];
         e = comb_of(pt_terms, cfg_invert);
         @(negedge pin_clk); #1;
         chk("R2 pin_clk capture", pin_out, e, 8'h0F);
         chk("R3 pin_clk ignored by pt-clocked cells", pin_out, 8'hF0, 8'hF0);
      end
      for (int n = 0; n < 10; n++) begin
         @(negedge pin_clk);
         rand_terms(); draw(w); cfg_invert = w[7:0];
         #1 pt_clk = 8'hF0;
         #1 pt_clk = 8'h00;
         #1;
         chk("R3 pt_clk capture", pin_out, comb_of(pt_terms, cfg_invert), 8'hF0);
      end

      // R4: product-term clear on cells 4,5 only
      cfg_fb_reg = '1;
      load_upper(1'b1);
      cfg_clr_pt = 8'h30;
      @(negedge pin_clk);
      pt_clr = 8'hF0;
      #1;
      chk("R4 pt clear selective", pin_out, 8'hC0, 8'hF0);
      @(negedge pin_clk); #1;
      chk("R4 clear held across pin_clk", fb_out, 8'hC0, 8'hF0);
      pt_clr = 8'h00;

      // R5: preset
      load_upper(1'b0);
      chk("R5 upper loaded 0", pin_out, 8'h00, 8'hF0);
      @(negedge pin_clk);
      pt_pre = 8'hF0;
      #1;
      chk("R5 preset sets", pin_out, 8'hF0, 8'hF0);
      @(negedge pin_clk);
      pt_pre = 8'h00;
      @(negedge pin_clk); #1;
      chk("R5 preset value held", pin_out, 8'hF0, 8'hF0);

      // R6: clear and preset together
      @(negedge pin_clk);
      pt_pre = 8'hF0; pt_clr = 8'hF0;
      #1;
      chk("R6 clear beats preset", pin_out, 8'hC0, 8'hF0);
      @(negedge pin_clk);
      pt_pre = 8'h00; pt_clr = 8'h00;
      #1;
      chk("R6 after release", pin_out, 8'hC0, 8'hF0);

      // R9: gated device reset
      load_upper(1'b1);
      rst_en = 0; dev_rst = 1;
      #1;
      chk("R9 reset ignored when rst_en=0", pin_out, 8'hF0, 8'hF0);
      dev_rst = 0;
      #1 rst_en = 1; cfg_clr_rst = 8'h7F;
      #1 dev_rst = 1;
      #1;
      chk("R9 reset per-cell select", pin_out, 8'h80, 8'hF0);
      dev_rst = 0;

      // R7: buried feedback, pin shows comb while feedback shows stored bit
      @(negedge pin_clk);
      cfg_reg_out = '0; cfg_fb_reg = 8'hF0;
      pt_terms = '0; cfg_invert = 8'hF0;
      #1;
      chk("R7 pin shows comb", pin_out, 8'hF0, 8'hF0);
      chk("R7 feedback from register", fb_out, 8'h80, 8'hF0);
      cfg_fb_reg = '0;
      #1;
      chk("R7 feedback from comb", fb_out, 8'hF0, 8'hF0);

      // R8: output enable and input bus
      oe_set   = '{8'h00, 8'hFF, 8'hA5};
      mode_set = '{8'h00, 8'hFF, 8'h3C};
      for (int a = 0; a < 3; a++) begin
         for (int m = 0; m < 3; m++) begin
            @(negedge pin_clk);
            pt_oe = oe_set[a]; cfg_pin_in = mode_set[m];
            draw(w); pin_in = w[7:0];
            #1;
            chk("R8 output enable", pin_oe, pt_oe & ~cfg_pin_in, 8'hFF);
            chk("R8 input bus", in_bus, pin_in & cfg_pin_in, 8'hFF);
         end
      end

      @(negedge pin_clk);
      finish_run();
   end
endmodule